// File: doc/BRIEF.md
# Cross-Domain Mailbox Register

This block carries one message word from a writer clock domain to a reader clock domain. It sits beside a FIFO and bypasses it. The writer stores a word by raising its port enable and its mailbox select together. The block then raises a mail-full flag in the writer domain and, a few reader cycles later, a mail-available flag in the reader domain. The reader takes the word by raising its own enable and mailbox select together. That frees the mailbox. A toggle handshake carries the release back to the writer, which then drops mail-full.

The two clocks are independent. They may be asynchronous to each other or be the same clock. Occupancy crosses the domains only as toggles, each through a two-stage synchronizer. The stored word is never rewritten while the mailbox is occupied, so it reaches the reader as a stable value. One active-low reset serves both domains. Its assertion is asynchronous, and its release is synchronized separately into each clock.

Top module: `mbox_xdomain`

## Requirements
- R1: While reset is asserted and just after it is released, mail_full and mail_avail are both 0. Asserting reset while mail is pending clears both flags.
- R2: A write strobe (wr_en=1 and wr_mbsel=1) sampled on a wr_clk rising edge while mail_full=0 stores wr_data. After that edge, mail_full reads 1.
- R3: A wr_clk edge with wr_en=1 and wr_mbsel=0 stores nothing, and mail_full stays 0.
- R4: A write strobe while mail_full=1 is ignored. The word already stored is the one the reader later receives.
- R5: Within 6 rd_clk cycles of a store, mail_avail reads 1 and rd_data equals the stored word.
- R6: A read strobe (rd_en=1 and rd_mbsel=1) sampled on a rd_clk rising edge while mail_avail=1 consumes the word. After that edge, mail_avail reads 0.
- R7: A rd_clk edge with rd_mbsel=0, or one with mail_avail=0, has no effect. Pending mail stays available, and a later store is still signalled.
- R8: Within 8 wr_clk cycles of a read, mail_full returns to 0, and a new write strobe is accepted.
- R9: While mail_avail stays 1, rd_data does not change.
- R10: Under continuous write and read strobes, every accepted word is delivered exactly once and in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Active-low reset for both domains, asserted asynchronously |
| wr_clk | input | 1 | Writer clock |
| wr_en | input | 1 | Writer port enable |
| wr_mbsel | input | 1 | Writer mailbox select |
| wr_data | input | W | Word to store |
| mail_full | output | 1 | Mailbox occupied (writer domain) |
| rd_clk | input | 1 | Reader clock |
| rd_en | input | 1 | Reader port enable |
| rd_mbsel | input | 1 | Reader mailbox select |
| rd_data | output | W | Stored word |
| mail_avail | output | 1 | New mail waiting (reader domain) |

## Verification
Two events can fall in the same writer cycle: the returning release clears mail-full, and a write strobe that is already being held arrives. The bench provokes this by holding both strobes high without a break while the data word changes on every writer cycle. The writer clock runs at a different rate from the reader clock, so the release lands at varying points in that cycle. The judgement is end to end. A word counts as accepted only on an edge where mail-full was low, and each accepted word must appear at the reader exactly once, in the order accepted. A write lost or doubled at the clear edge breaks the sequence.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  localparam int unsigned MBOX_DEF_WIDTH = 36;
  localparam int unsigned MBOX_DEF_SYNC  = 2;
endpackage

// File: rtl/mbox_rst_sync.sv
module mbox_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign srst_n = chain_q[STAGES-1];
endmodule

// File: rtl/mbox_bit_sync.sv
module mbox_bit_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] stage_q;

  genvar gi;
  generate
    for (gi = 0; gi < STAGES; gi++) begin : g_stage
      logic nxt;
      if (gi == 0) begin : g_first
        assign nxt = d;
      end else begin : g_rest
        assign nxt = stage_q[gi-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[gi] <= 1'b0;
        else        stage_q[gi] <= nxt;
      end
    end
  endgenerate

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/mbox_wr_port.sv
module mbox_wr_port #(
  parameter int unsigned W      = 36,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en_i,
  input  logic         wr_mbsel_i,
  input  logic [W-1:0] wr_data_i,
  input  logic         ack_tog_i,
  output logic         full_o,
  output logic         req_tog_o,
  output logic [W-1:0] word_o
);
  logic         req_q, req_d;
  logic [W-1:0] word_q, word_d;
  logic         ack_s;
  logic         store;

  mbox_bit_sync #(.STAGES(STAGES)) u_ack_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (ack_tog_i),
    .q     (ack_s)
  );

  // Occupied while the request toggle leads the returned acknowledge.
  assign full_o = req_q ^ ack_s;
  assign store  = wr_en_i & wr_mbsel_i & ~full_o;

  always_comb begin
    req_d  = req_q;
    word_d = word_q;
    if (store) begin
      req_d  = ~req_q;
      word_d = wr_data_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q  <= 1'b0;
      word_q <= '0;
    end else begin
      req_q  <= req_d;
      word_q <= word_d;
    end
  end

  assign req_tog_o = req_q;
  assign word_o    = word_q;
endmodule

// File: rtl/mbox_rd_port.sv
module mbox_rd_port #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rd_en_i,
  input  logic rd_mbsel_i,
  input  logic req_tog_i,
  output logic avail_o,
  output logic ack_tog_o
);
  logic ack_q, ack_d;
  logic req_s;
  logic take;

  mbox_bit_sync #(.STAGES(STAGES)) u_req_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (req_tog_i),
    .q     (req_s)
  );

  assign avail_o = req_s ^ ack_q;
  assign take    = rd_en_i & rd_mbsel_i & avail_o;

  always_comb begin
    ack_d = ack_q;
    if (take) ack_d = ~ack_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ack_q <= 1'b0;
    else        ack_q <= ack_d;
  end

  assign ack_tog_o = ack_q;
endmodule

// File: rtl/mbox_xdomain.sv
module mbox_xdomain #(
  parameter int unsigned W      = mbox_pkg::MBOX_DEF_WIDTH,
  parameter int unsigned STAGES = mbox_pkg::MBOX_DEF_SYNC
) (
  input  logic         rst_n,
  input  logic         wr_clk,
  input  logic         wr_en,
  input  logic         wr_mbsel,
  input  logic [W-1:0] wr_data,
  output logic         mail_full,
  input  logic         rd_clk,
  input  logic         rd_en,
  input  logic         rd_mbsel,
  output logic [W-1:0] rd_data,
  output logic         mail_avail
);
  logic wr_rst_sync_n;
  logic rd_rst_sync_n;
  logic req_tog;
  logic ack_tog;

  mbox_rst_sync #(.STAGES(STAGES)) u_wr_rst (
    .clk    (wr_clk),
    .arst_n (rst_n),
    .srst_n (wr_rst_sync_n)
  );

  mbox_rst_sync #(.STAGES(STAGES)) u_rd_rst (
    .clk    (rd_clk),
    .arst_n (rst_n),
    .srst_n (rd_rst_sync_n)
  );

  mbox_wr_port #(.W(W), .STAGES(STAGES)) u_wr (
    .clk        (wr_clk),
    .rst_n      (wr_rst_sync_n),
    .wr_en_i    (wr_en),
    .wr_mbsel_i (wr_mbsel),
    .wr_data_i  (wr_data),
    .ack_tog_i  (ack_tog),
    .full_o     (mail_full),
    .req_tog_o  (req_tog),
    .word_o     (rd_data)
  );

  mbox_rd_port #(.STAGES(STAGES)) u_rd (
    .clk        (rd_clk),
    .rst_n      (rd_rst_sync_n),
    .rd_en_i    (rd_en),
    .rd_mbsel_i (rd_mbsel),
    .req_tog_i  (req_tog),
    .avail_o    (mail_avail),
    .ack_tog_o  (ack_tog)
  );
endmodule

// File: rtl/mbox_xdomain_chk.sv
module mbox_xdomain_chk #(
  parameter int unsigned W = 36
) (
  input logic         wr_clk,
  input logic         rd_clk,
  input logic         wr_rst_n,
  input logic         rd_rst_n,
  input logic         wr_en,
  input logic         wr_mbsel,
  input logic         mail_full,
  input logic         rd_en,
  input logic         rd_mbsel,
  input logic         mail_avail,
  input logic [W-1:0] rd_data
);
  AST_RESET_EMPTY: assert property (@(posedge wr_clk)
    !wr_rst_n |-> !mail_full); // R1

  AST_STORE_SETS_FULL: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    (wr_en && wr_mbsel && !mail_full) |=> mail_full); // R2

  AST_UNSEL_IGNORED: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    (!(wr_en && wr_mbsel) && !mail_full) |=> !mail_full); // R3

  AST_NO_OVERWRITE: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    mail_full |=> $stable(rd_data)); // R4

  AST_READ_CLEARS: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    (rd_en && rd_mbsel && mail_avail) |=> !mail_avail); // R6

  AST_DATA_HELD: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    (mail_avail && $past(mail_avail)) |-> $stable(rd_data)); // R9
endmodule

bind mbox_xdomain mbox_xdomain_chk #(.W(W)) u_chk (
  .wr_clk     (wr_clk),
  .rd_clk     (rd_clk),
  .wr_rst_n   (wr_rst_sync_n),
  .rd_rst_n   (rd_rst_sync_n),
  .wr_en      (wr_en),
  .wr_mbsel   (wr_mbsel),
  .mail_full  (mail_full),
  .rd_en      (rd_en),
  .rd_mbsel   (rd_mbsel),
  .mail_avail (mail_avail),
  .rd_data    (rd_data)
);

// File: tb/tb_mbox_xdomain.sv
module tb_mbox_xdomain;
  localparam int unsigned W = 36;

  logic         rst_n;
  logic         wr_clk, rd_clk;
  logic         wr_en, wr_mbsel, rd_en, rd_mbsel;
  logic [W-1:0] wr_data, rd_data;
  logic         mail_full, mail_avail;

  int checks = 0;
  int errors = 0;
  int delivered = 0;
  bit done = 0;
  logic [W-1:0] sb_q[$];

  mbox_xdomain #(.W(W)) dut (
    .rst_n(rst_n), .wr_clk(wr_clk), .wr_en(wr_en), .wr_mbsel(wr_mbsel),
    .wr_data(wr_data), .mail_full(mail_full), .rd_clk(rd_clk), .rd_en(rd_en),
    .rd_mbsel(rd_mbsel), .rd_data(rd_data), .mail_avail(mail_avail)
  );

  initial wr_clk = 0;
  always #2 wr_clk = ~wr_clk;          // 250 MHz
  initial rd_clk = 0;
  always #3.1 rd_clk = ~rd_clk;

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_drive(input logic en, input logic sel, input logic [W-1:0] d);
    @(posedge wr_clk); #1;
    wr_en = en; wr_mbsel = sel; wr_data = d;
  endtask

  task automatic rd_drive(input logic en, input logic sel);
    @(posedge rd_clk); #1;
    rd_en = en; rd_mbsel = sel;
  endtask

  // Scoreboard driver side: a strobe seen with mail_full low is accepted (R2, R4).
  always @(negedge wr_clk)
    if (rst_n && wr_en && wr_mbsel && !mail_full) sb_q.push_back(wr_data);

  // Scoreboard monitor side: a strobe seen with mail_avail high delivers (R10).
  always @(negedge rd_clk)
    if (rst_n && rd_en && rd_mbsel && mail_avail) begin
      if (sb_q.size() == 0) check(1'b0, "R10 unexpected delivery", rd_data, 0);
      else begin
        check(rd_data == sb_q[0], "R10 delivered word", rd_data, sb_q[0]);
        void'(sb_q.pop_front());
        delivered++;
      end
    end

  initial begin
    #150000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic wait_avail();
    for (int i = 0; i < 6 && !mail_avail; i++) @(negedge rd_clk);
  endtask

  task automatic wait_free();
    for (int i = 0; i < 8 && mail_full; i++) @(negedge wr_clk);
  endtask

  initial begin
    logic [W-1:0] held;
    rst_n = 0; wr_en = 0; wr_mbsel = 0; wr_data = '0; rd_en = 0; rd_mbsel = 0;
    #13;
    check(!mail_full, "R1 full in reset", mail_full, 0);
    check(!mail_avail, "R1 avail in reset", mail_avail, 0);
    rst_n = 1;
    repeat (10) @(negedge wr_clk);
    check(!mail_full && !mail_avail, "R1 flags after release", {mail_full, mail_avail}, 0);

    // R3: enable without mailbox select
    wr_drive(1, 0, 36'h0_1111_2222);
    wr_drive(0, 0, '0);
    repeat (8) @(negedge rd_clk);
    check(!mail_full, "R3 full after unselected write", mail_full, 0);
    check(!mail_avail, "R3 avail after unselected write", mail_avail, 0);

    // R2 / R4: store then try to overwrite
    wr_drive(1, 1, 36'hA_5A5A_0001);
    wr_drive(1, 1, 36'h5_0000_BEEF);
    @(negedge wr_clk);
    check(mail_full, "R2 full after store", mail_full, 1);
    repeat (3) wr_drive(1, 1, 36'h5_0000_BEEF);
    wr_drive(0, 0, '0);
    wait_avail();
    check(mail_avail, "R5 avail after store", mail_avail, 1);
    check(rd_data == 36'hA_5A5A_0001, "R4 R5 stored word kept", rd_data, 36'hA_5A5A_0001);

    // R7 / R9: read without mailbox select
    held = rd_data;
    rd_drive(1, 0);
    repeat (3) @(negedge rd_clk);
    check(mail_avail, "R7 avail after unselected read", mail_avail, 1);
    check(rd_data == held, "R9 data held", rd_data, held);

    // R6 / R8: real read
    rd_drive(1, 1);
    rd_drive(0, 0);
    @(negedge rd_clk);
    check(!mail_avail, "R6 avail after read", mail_avail, 0);
    wait_free();
    check(!mail_full, "R8 full released", mail_full, 0);

    // R7: read while empty, then a new store still signals
    rd_drive(1, 1);
    repeat (3) rd_drive(1, 1);
    rd_drive(0, 0);
    wr_drive(1, 1, 36'h3_C0DE_7777);
    wr_drive(0, 0, '0);
    @(negedge wr_clk);
    check(mail_full, "R8 new write accepted", mail_full, 1);
    wait_avail();
    check(mail_avail, "R7 store signalled after empty read", mail_avail, 1);
    check(rd_data == 36'h3_C0DE_7777, "R5 second word", rd_data, 36'h3_C0DE_7777);

    // R1: reset with mail pending
    rst_n = 0;
    #5;
    check(!mail_full && !mail_avail, "R1 reset clears pending", {mail_full, mail_avail}, 0);
    sb_q.delete();
    rst_n = 1;
    repeat (10) @(negedge wr_clk);
    check(!mail_avail, "R1 avail after second reset", mail_avail, 0);

    // R10: continuous strobes on both sides
    delivered = 0;
    rd_drive(1, 1);
    for (int k = 0; k < 300; k++) wr_drive(1, 1, W'(36'h9_0000_0000 + k));
    wr_drive(0, 0, '0);
    repeat (30) @(negedge rd_clk);
    check(sb_q.size() == 0, "R10 all words drained", sb_q.size(), 0);
    check(delivered > 10, "R10 stream progressed", delivered, 11);
    rd_drive(0, 0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule